// File: doc/BRIEF.md
# PWM Input Capture Unit

This block measures an external pulse-width-modulated waveform against a single free-running time base. A programmable clock divider paces a counter that climbs from zero to a programmable limit and then returns to zero. Every measured input is shared by a pair of capture slots. One slot latches the counter on the rising transitions of that input and the other latches it on the falling transitions. Software subtracts the latched values to get the period and the high time, and treats a smaller later value as one wrap of the counter.

Each input passes through a two-flop synchroniser before its transitions are detected. An edge divider per slot can limit captures to every 2nd, 4th or 8th qualifying transition. This makes it possible to time fast signals over several cycles. Each slot has a sticky "new value" flag and an overrun flag. Software drives everything through a small word-addressed register port. The read data is combinational, and a read of a capture slot acknowledges that slot.

Top module: `pwm_capture_unit`

## Requirements
- R1: After a synchronous reset every register reads zero: control (address 0), divider preload (1), limit preload (2), and for each pair p the config (4+4p), slot A value (5+4p), slot B value (6+4p) and status (7+4p).
- R2: With the run bit set (control bit 0), the counter advances once every DIV+1 clocks, where DIV is the active divider value. It goes from 0 up to the active limit and on the next advance returns to 0.
- R3: Writes to the divider preload and the limit preload have no effect on counting until a write to address 3 with bit 0 set. That write copies both preloads into the active values and clears the counter and the divider phase in the same clock.
- R4: With config bit 2 (swap) clear, a rising input transition loads slot A. The value loaded is the counter value present after the second rising clock edge that follows the first clock edge at which the new level is sampled, and it appears one clock later.
- R5: With swap clear, a falling input transition loads slot B, with the same timing as R4.
- R6: With swap set, slot A responds to falling transitions and slot B to rising transitions.
- R7: Config bits [1:0] set the edge divider of both slots of a pair. Code 0, 1, 2 and 3 give a capture on every 1st, 2nd, 4th and 8th qualifying transition.
- R8: While a pair's enable (control bit 1+p) is clear, its slots capture nothing and their edge-divider phase is held at zero. After re-enable, the full divide count starts again.
- R9: Status bit 0 (slot A) and bit 1 (slot B) are set by a capture and cleared by reading that slot's value address.
- R10: A capture into a slot whose flag is still set sets that slot's overrun bit (status bit 2 for A, bit 3 for B) and replaces the value. Reading the slot clears the overrun bit.
- R11: Transitions on one pair's input have no effect on the other pair's slots or status.
- R12: With the run bit clear the counter holds its value, and captures still latch that frozen value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pwm_in | input | NPAIR | Measured signals, one per pair, asynchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (acknowledges capture slots) |
| reg_addr | input | ADDR_W | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |

## Verification
Single transitions on pair 0 are driven with the unit-rate time base, with a short wrapping limit, and with a divided clock. Comparing these against a counter model shows the capture latency, the wrap point and the divider pacing apart. Rise/fall trains with the swap bit and each edge-divide code separate slot routing from capture thinning. A disable in the middle of a divide count shows whether the phase was cleared. Back-to-back captures without reads, a transition on the second pair and a stopped counter show overrun handling, pair isolation and the frozen time base.

// File: rtl/pcu_pkg.sv
// Shared constants and types for the PWM input capture unit.
// Assumes word addressing; pair registers repeat with a fixed stride.
package pcu_pkg;
    localparam int DATA_W      = 32;
    localparam int REG_CTRL    = 0;
    localparam int REG_PSC     = 1;
    localparam int REG_LIMIT   = 2;
    localparam int REG_EVT     = 3;
    localparam int PAIR_BASE   = 4;
    localparam int PAIR_STRIDE = 4;
    localparam int OFS_CFG     = 0;
    localparam int OFS_CAPA    = 1;
    localparam int OFS_CAPB    = 2;
    localparam int OFS_STAT    = 3;

    typedef enum logic [1:0] {
        EDGE_EVERY1 = 2'd0,
        EDGE_EVERY2 = 2'd1,
        EDGE_EVERY4 = 2'd2,
        EDGE_EVERY8 = 2'd3
    } edge_div_e;

    typedef struct packed {
        logic      swap;
        edge_div_e div;
    } pair_cfg_t;

    // Number of qualifying transitions per capture for a divide code.
    function automatic logic [3:0] edges_per_capture(input edge_div_e d);
        return 4'd1 << d;
    endfunction
endpackage

// File: rtl/pcu_timebase.sv
// Time base: clock divider plus wrapping up-counter.
// Active divider and limit change only on the update strobe, which also
// restarts the counter. Assumes update and run come from registered logic.
module pcu_timebase #(
    parameter int CNT_W = 16,
    parameter int PSC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             update,
    input  logic [PSC_W-1:0] psc_pre,
    input  logic [CNT_W-1:0] lim_pre,
    output logic [CNT_W-1:0] count
);
    logic [PSC_W-1:0] psc_act;
    logic [PSC_W-1:0] phase;
    logic [CNT_W-1:0] lim_act;
    logic [CNT_W-1:0] cnt_q;
    logic             tick;

    assign tick  = run && (phase == psc_act);
    assign count = cnt_q;

    // Purpose: take the preloaded divider and limit on update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            psc_act <= '0;
            lim_act <= '0;
        end else if (update) begin
            psc_act <= psc_pre;
            lim_act <= lim_pre;
        end
    end

    // Purpose: advance the divider phase while running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (update) begin
            phase <= '0;
        end else if (run) begin
            phase <= tick ? '0 : phase + 1'b1;
        end
    end

    // Purpose: step the counter on each divider tick, wrapping at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (update) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= (cnt_q == lim_act) ? '0 : cnt_q + 1'b1;
        end
    end

    p_update_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        update |=> (cnt_q == '0 && phase == '0));
    p_within_limit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= lim_act);
    p_wrap_to_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !update && cnt_q == lim_act) |=> cnt_q == '0);
    p_hold_when_stopped_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !update) |=> $stable(cnt_q));
endmodule

// File: rtl/pcu_cap_slot.sv
// One capture slot: edge divider, value latch, new-value and overrun flags.
// Assumes edge_hit is a single-cycle pulse from synchronised logic.
module pcu_cap_slot
    import pcu_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             edge_hit,
    input  edge_div_e        div,
    input  logic [CNT_W-1:0] count,
    input  logic             rd_ack,
    output logic [CNT_W-1:0] value,
    output logic             flag,
    output logic             ovr
);
    logic [2:0] ecnt;
    logic [3:0] need;
    logic       strobe;

    assign need   = edges_per_capture(div);
    assign strobe = en && edge_hit && ({1'b0, ecnt} >= need - 4'd1);

    // Purpose: count qualifying transitions between captures.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ecnt <= '0;
        end else if (!en) begin
            ecnt <= '0;
        end else if (edge_hit) begin
            ecnt <= strobe ? '0 : ecnt + 1'b1;
        end
    end

    // Purpose: latch the time base on a capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value <= '0;
        end else if (strobe) begin
            value <= count;
        end
    end

    // Purpose: maintain sticky new-value and overrun flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
            ovr  <= 1'b0;
        end else if (strobe) begin
            flag <= 1'b1;
            ovr  <= rd_ack ? 1'b0 : (ovr | flag);
        end else if (rd_ack) begin
            flag <= 1'b0;
            ovr  <= 1'b0;
        end
    end

    p_capture_sets_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> flag);
    p_read_clears_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ack && !strobe) |=> (!flag && !ovr));
    p_overrun_needs_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr) |-> $past(flag));
    p_disabled_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (ecnt == '0 && $stable(value)));
endmodule

// File: rtl/pcu_pair.sv
// Capture pair: synchronises one input, detects its transitions and routes
// rising/falling events to two slots (swapped when cfg.swap is set).
// Assumes the input is asynchronous to clk.
module pcu_pair
    import pcu_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sig_in,
    input  logic             en,
    input  pair_cfg_t        cfg,
    input  logic [CNT_W-1:0] count,
    input  logic             ack_a,
    input  logic             ack_b,
    output logic [CNT_W-1:0] val_a,
    output logic [CNT_W-1:0] val_b,
    output logic [3:0]       stat
);
    logic [SYNC_STAGES:0] shreg;
    logic                 level, level_d, rise, fall;
    logic                 hit_a, hit_b, flag_a, flag_b, ovr_a, ovr_b;

    // Purpose: synchronise the input and keep one extra stage for edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
        end else begin
            shreg <= {shreg[SYNC_STAGES-1:0], sig_in};
        end
    end

    assign level   = shreg[SYNC_STAGES-1];
    assign level_d = shreg[SYNC_STAGES];
    assign rise    = level & ~level_d;
    assign fall    = ~level & level_d;
    assign hit_a   = cfg.swap ? fall : rise;
    assign hit_b   = cfg.swap ? rise : fall;
    assign stat    = {ovr_b, ovr_a, flag_b, flag_a};

    pcu_cap_slot #(.CNT_W(CNT_W)) u_slot_a (
        .clk(clk), .rst_n(rst_n), .en(en), .edge_hit(hit_a), .div(cfg.div),
        .count(count), .rd_ack(ack_a), .value(val_a), .flag(flag_a), .ovr(ovr_a)
    );

    pcu_cap_slot #(.CNT_W(CNT_W)) u_slot_b (
        .clk(clk), .rst_n(rst_n), .en(en), .edge_hit(hit_b), .div(cfg.div),
        .count(count), .rd_ack(ack_b), .value(val_b), .flag(flag_b), .ovr(ovr_b)
    );
endmodule

// File: rtl/pwm_capture_unit.sv
// Top of the PWM input capture unit: register port, shared time base and
// NPAIR capture pairs. Read data is combinational; a read strobe on a slot
// address acknowledges that slot. Assumes NPAIR, CNT_W, PSC_W < 32.
module pwm_capture_unit
    import pcu_pkg::*;
#(
    parameter int NPAIR       = 2,
    parameter int CNT_W       = 16,
    parameter int PSC_W       = 16,
    parameter int ADDR_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPAIR-1:0]  pwm_in,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata
);
    localparam int CFG_W = $bits(pair_cfg_t);

    logic                          run_q;
    logic [NPAIR-1:0]              pen_q;
    logic [PSC_W-1:0]              psc_pre;
    logic [CNT_W-1:0]              lim_pre;
    logic [CNT_W-1:0]              count;
    logic                          update;
    logic [NPAIR-1:0][CFG_W-1:0]   cfg_v;
    logic [NPAIR-1:0][CNT_W-1:0]   val_a_v;
    logic [NPAIR-1:0][CNT_W-1:0]   val_b_v;
    logic [NPAIR-1:0][3:0]         stat_v;

    assign update = reg_wr && (reg_addr == ADDR_W'(REG_EVT)) && reg_wdata[0];

    // Purpose: hold control bits and the time-base preloads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q   <= 1'b0;
            pen_q   <= '0;
            psc_pre <= '0;
            lim_pre <= '0;
        end else if (reg_wr) begin
            if (reg_addr == ADDR_W'(REG_CTRL)) begin
                run_q <= reg_wdata[0];
                pen_q <= reg_wdata[NPAIR:1];
            end
            if (reg_addr == ADDR_W'(REG_PSC)) begin
                psc_pre <= reg_wdata[PSC_W-1:0];
            end
            if (reg_addr == ADDR_W'(REG_LIMIT)) begin
                lim_pre <= reg_wdata[CNT_W-1:0];
            end
        end
    end

    pcu_timebase #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_tb (
        .clk(clk), .rst_n(rst_n), .run(run_q), .update(update),
        .psc_pre(psc_pre), .lim_pre(lim_pre), .count(count)
    );

    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        localparam int BASE = PAIR_BASE + PAIR_STRIDE * p;
        pair_cfg_t cfg_r;
        logic      ack_a, ack_b;

        // Purpose: hold this pair's swap bit and edge-divide code.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg_r <= '0;
            end else if (reg_wr && reg_addr == ADDR_W'(BASE + OFS_CFG)) begin
                cfg_r <= pair_cfg_t'(reg_wdata[CFG_W-1:0]);
            end
        end

        assign ack_a    = reg_rd && (reg_addr == ADDR_W'(BASE + OFS_CAPA));
        assign ack_b    = reg_rd && (reg_addr == ADDR_W'(BASE + OFS_CAPB));
        assign cfg_v[p] = cfg_r;

        pcu_pair #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_pair (
            .clk(clk), .rst_n(rst_n), .sig_in(pwm_in[p]), .en(pen_q[p]),
            .cfg(cfg_r), .count(count), .ack_a(ack_a), .ack_b(ack_b),
            .val_a(val_a_v[p]), .val_b(val_b_v[p]), .stat(stat_v[p])
        );
    end

    // Purpose: select read data by address.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(REG_CTRL)) begin
            reg_rdata = DATA_W'({pen_q, run_q});
        end else if (reg_addr == ADDR_W'(REG_PSC)) begin
            reg_rdata = DATA_W'(psc_pre);
        end else if (reg_addr == ADDR_W'(REG_LIMIT)) begin
            reg_rdata = DATA_W'(lim_pre);
        end
        for (int p = 0; p < NPAIR; p++) begin
            if (reg_addr == ADDR_W'(PAIR_BASE + PAIR_STRIDE * p + OFS_CFG)) begin
                reg_rdata = DATA_W'(cfg_v[p]);
            end
            if (reg_addr == ADDR_W'(PAIR_BASE + PAIR_STRIDE * p + OFS_CAPA)) begin
                reg_rdata = DATA_W'(val_a_v[p]);
            end
            if (reg_addr == ADDR_W'(PAIR_BASE + PAIR_STRIDE * p + OFS_CAPB)) begin
                reg_rdata = DATA_W'(val_b_v[p]);
            end
            if (reg_addr == ADDR_W'(PAIR_BASE + PAIR_STRIDE * p + OFS_STAT)) begin
                reg_rdata = DATA_W'(stat_v[p]);
            end
        end
    end
endmodule

// File: tb/sim_pwm_capture_unit.sv
module sim_pwm_capture_unit;
    localparam logic [3:0] A_CTRL = 4'd0, A_PSC = 4'd1, A_LIM = 4'd2, A_EVT = 4'd3;

    typedef struct packed {
        logic [1:0]  pair;
        logic        is_b;
        logic [15:0] val;
    } sb_item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  pwm_in = 2'b00;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [3:0]  reg_addr = 4'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;

    int checks = 0, failures = 0;
    bit done = 1'b0;
    sb_item_t sbq[$];
    string    reqq[$];
    logic [15:0] last_a [2];
    logic [15:0] last_b [2];

    // time-base model built from R2/R3/R12
    logic        m_run;
    logic [15:0] m_sp, m_sl, m_ap, m_al, m_ph, m_cnt;

    always #5 clk = ~clk;

    pwm_capture_unit u0 (
        .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_run <= 1'b0; m_sp <= '0; m_sl <= '0; m_ap <= '0; m_al <= '0;
            m_ph <= '0; m_cnt <= '0;
        end else begin
            if (reg_wr && reg_addr == A_CTRL) m_run <= reg_wdata[0];
            if (reg_wr && reg_addr == A_PSC)  m_sp  <= reg_wdata[15:0];
            if (reg_wr && reg_addr == A_LIM)  m_sl  <= reg_wdata[15:0];
            if (reg_wr && reg_addr == A_EVT && reg_wdata[0]) begin
                m_ap <= m_sp; m_al <= m_sl; m_ph <= '0; m_cnt <= '0;
            end else if (m_run) begin
                if (m_ph == m_ap) begin
                    m_ph  <= '0;
                    m_cnt <= (m_cnt == m_al) ? 16'd0 : m_cnt + 16'd1;
                end else begin
                    m_ph <= m_ph + 16'd1;
                end
            end
        end
    end

    function automatic logic [3:0] pa(input int p, input int ofs);
        return 4'(4 + 4 * p + ofs);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk); reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    task automatic rd_check(input logic [3:0] a, input logic [31:0] exp, input string req);
        logic [31:0] d;
        rd(a, d);
        check(req, d, exp);
    endtask

    // Driver: change one input and report the counter value a capture must hold.
    task automatic set_in(input int p, input logic v, output logic [15:0] c);
        @(negedge clk); pwm_in[p] = v;
        @(posedge clk); @(posedge clk); #1 c = m_cnt;
        @(posedge clk); #1;
    endtask

    task automatic sb_push(input int p, input logic b, input logic [15:0] v, input string r);
        sbq.push_back('{pair: 2'(p), is_b: b, val: v});
        reqq.push_back(r);
    endtask

    // Monitor: pop expected captures and compare with the slot flag and value.
    task automatic sb_drain();
        while (sbq.size() > 0) begin
            sb_item_t e;
            string r;
            logic [31:0] d;
            e = sbq.pop_front();
            r = reqq.pop_front();
            rd(pa(int'(e.pair), 3), d);
            check({r, " flag"}, {31'd0, e.is_b ? d[1] : d[0]}, 32'd1);
            rd(pa(int'(e.pair), e.is_b ? 2 : 1), d);
            check({r, " value"}, d, {16'd0, e.val});
            if (e.is_b) last_b[e.pair] = e.val; else last_a[e.pair] = e.val;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [15:0] c, c2, cb;
        last_a[0] = '0; last_a[1] = '0; last_b[0] = '0; last_b[1] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd_check(A_CTRL, 0, "R1 ctrl");
        rd_check(A_PSC, 0, "R1 psc");
        rd_check(A_LIM, 0, "R1 limit");
        rd_check(pa(0, 0), 0, "R1 cfg0");
        rd_check(pa(0, 1), 0, "R1 slotA0");
        rd_check(pa(1, 2), 0, "R1 slotB1");
        rd_check(pa(0, 3), 0, "R1 stat0");

        // R3: preloads inert before update; counter stays at zero
        wr(A_PSC, 0); wr(A_LIM, 999);
        wr(A_CTRL, 32'h7);
        repeat (6) @(negedge clk);
        set_in(0, 1'b1, c); check("R3 count inert before update", {16'd0, c}, 0);
        sb_push(0, 1'b0, c, "R3"); sb_drain();

        // R4/R5: edges with the unit-rate time base
        wr(A_EVT, 1);
        repeat (13) @(negedge clk);
        set_in(0, 1'b0, c); sb_push(0, 1'b1, c, "R5 fall to B"); sb_drain();
        repeat (7) @(negedge clk);
        set_in(0, 1'b1, c); sb_push(0, 1'b0, c, "R4 rise to A"); sb_drain();
        set_in(0, 1'b0, c); sb_push(0, 1'b1, c, "R5 fall to B"); sb_drain();

        // R2: short limit wraps, then divided clock
        wr(A_LIM, 9); wr(A_EVT, 1);
        for (int i = 0; i < 4; i++) begin
            repeat (3 + 2 * i) @(negedge clk);
            set_in(0, 1'b1, c); sb_push(0, 1'b0, c, "R2 wrap A");
            set_in(0, 1'b0, c); sb_push(0, 1'b1, c, "R2 wrap B");
            sb_drain();
        end
        wr(A_PSC, 2); wr(A_LIM, 999); wr(A_EVT, 1);
        repeat (20) @(negedge clk);
        set_in(0, 1'b1, c); sb_push(0, 1'b0, c, "R2 divided A");
        repeat (11) @(negedge clk);
        set_in(0, 1'b0, c); sb_push(0, 1'b1, c, "R2 divided B");
        sb_drain();
        wr(A_PSC, 0); wr(A_EVT, 1);

        // R6: swapped routing
        wr(pa(0, 0), 32'h4);
        set_in(0, 1'b1, c); sb_push(0, 1'b1, c, "R6 rise to B"); sb_drain();
        set_in(0, 1'b0, c); sb_push(0, 1'b0, c, "R6 fall to A"); sb_drain();

        // R7: every 4th transition
        wr(pa(0, 0), 32'h2);
        for (int i = 0; i < 4; i++) begin
            set_in(0, 1'b1, c); if (i == 3) sb_push(0, 1'b0, c, "R7 div4 A");
            set_in(0, 1'b0, c); if (i == 3) sb_push(0, 1'b1, c, "R7 div4 B");
            if (i == 0) rd_check(pa(0, 3), 0, "R7 no capture before 4th");
        end
        sb_drain();

        // R7/R8: every 2nd, disable mid-count
        wr(pa(0, 0), 32'h1);
        set_in(0, 1'b1, c); set_in(0, 1'b0, c);
        rd_check(pa(0, 3), 0, "R7 div2 first edge skipped");
        wr(A_CTRL, 32'h5);
        set_in(0, 1'b1, c); set_in(0, 1'b0, c);
        rd_check(pa(0, 3), 0, "R8 disabled no flag");
        rd_check(pa(0, 1), {16'd0, last_a[0]}, "R8 disabled value kept");
        wr(A_CTRL, 32'h7);
        set_in(0, 1'b1, c);
        rd_check(pa(0, 3), 0, "R8 phase cleared");
        set_in(0, 1'b0, c);
        set_in(0, 1'b1, c); sb_push(0, 1'b0, c, "R8 re-enabled A");
        set_in(0, 1'b0, c); sb_push(0, 1'b1, c, "R8 re-enabled B");
        sb_drain();

        // R9/R10: flags and overrun
        wr(pa(0, 0), 32'h0);
        set_in(0, 1'b1, c);
        rd_check(pa(0, 3), 32'h1, "R9 flag A set");
        set_in(0, 1'b0, cb);
        repeat (5) @(negedge clk);
        set_in(0, 1'b1, c2);
        rd_check(pa(0, 3), 32'h7, "R10 overrun A");
        rd_check(pa(0, 1), {16'd0, c2}, "R10 latest value");
        rd_check(pa(0, 3), 32'h2, "R9 read clears A");
        rd_check(pa(0, 2), {16'd0, cb}, "R9 value B");
        rd_check(pa(0, 3), 32'h0, "R9 read clears B");
        set_in(0, 1'b0, c); sb_push(0, 1'b1, c, "R9 B"); sb_drain();

        // R11: pair 1 isolated from pair 0
        set_in(1, 1'b1, c); sb_push(1, 1'b0, c, "R11 pair1 A");
        rd_check(pa(0, 3), 0, "R11 pair0 untouched");
        sb_drain();
        set_in(1, 1'b0, c); sb_push(1, 1'b1, c, "R11 pair1 B"); sb_drain();

        // R12: stopped counter, captures hold frozen value
        wr(A_CTRL, 32'h6);
        set_in(0, 1'b1, c); sb_push(0, 1'b0, c, "R12 frozen A"); sb_drain();
        repeat (20) @(negedge clk);
        set_in(0, 1'b0, c2); sb_push(0, 1'b1, c2, "R12 frozen B"); sb_drain();
        check("R12 counter held", {16'd0, last_b[0]}, {16'd0, last_a[0]});

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule